// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the address for one port of a dual-port memory. The external address bus loads a starting address into the block. After that, each burst cycle steps the address by one inside the block. A mask register selects which low address bits count, which sets the size of the burst window and the point where the count wraps. Address bits outside the mask keep the value they were loaded with. When the counting bits roll over from all ones to zero, an active-low wrap flag goes low. The flag stays low until the next load or reset.

A retransmit strobe sends the counter back to the address that was last loaded, so the same block can be replayed. The counter value or the mask value can be placed on the address return lines. A qualifying output-enable goes with it, so a host can see where the burst stands. The master reset is asynchronous and active low. Each cycle carries one operation: when several strobes arrive together, a fixed priority picks the one that acts.

Top module: `masked_burst_counter`

## Requirements
- R1: While `rstN` is low, and without waiting for a clock edge, the counter and the replay start address are zero, the mask is all ones and `cntIntN` is high.
- R2: `loadEn` has the highest priority. On the next edge it copies `addrIn` into both the counter and the replay start address, and it drives `cntIntN` high.
- R3: `incEn` adds one to the counter bits where the mask is 1, and carries stop at the top of the mask. Counter bits where the mask is 0 keep their value.
- R4: When no load, increment or retransmit takes effect in a cycle, the counter does not change.
- R5: An increment that starts with all masked counter bits at 1, under a nonzero mask, clears those bits and drives `cntIntN` low at the same edge. The flag stays low through further increments, retransmits and mask writes until a load or reset.
- R6: `maskWrEn` ranks second in priority and leaves the counter unchanged. It stores only the run of ones in `addrIn` that starts at bit 0: every bit at or above the lowest 0 is stored as 0. For example, `addrIn` = 0x0B stores 0x03.
- R7: `retxEn` ranks third in priority, above `incEn`. On the next edge it sets the counter to the replay start address and leaves `cntIntN` unchanged.
- R8: Readback is combinational. With `rdCntEn` high, `addrOut` shows the counter and `addrOe` is 1. With only `rdMaskEn` high, `addrOut` shows the mask and `addrOe` is 1. With neither high, `addrOut` is 0 and `addrOe` is 0.
- R9: With a mask of zero, an increment leaves both the counter and `cntIntN` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous master reset, active low |
| loadEn | input | 1 | Load the counter and replay start from `addrIn` |
| incEn | input | 1 | Step the counter within the mask |
| retxEn | input | 1 | Return the counter to the replay start |
| maskWrEn | input | 1 | Write the mask from `addrIn` |
| rdCntEn | input | 1 | Put the counter on `addrOut` |
| rdMaskEn | input | 1 | Put the mask on `addrOut` |
| addrIn | input | ADDR_W | External address / mask value |
| addrOut | output | ADDR_W | Readback value |
| addrOe | output | 1 | Readback drive enable |
| cntIntN | output | 1 | Wrap flag, active low |

## Verification
Increments run from an unaligned start under a full mask and under narrow masks. This shows whether carries stay inside the mask and whether the upper bits keep their loaded value. Wrap sequences are followed by more increments, a retransmit and then a load. This separates a flag that holds until load from one that clears on its own or never sets. The bench then drives colliding strobe pairs, non-contiguous and zero mask writes, and a long pseudo-random strobe run. These test the priority order, the mask trimming and the frozen counter under a zero mask, and a behavioural model is compared against the outputs every cycle.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  // One resolved operation per cycle plus readback selects
  typedef struct packed {
    logic load;
    logic maskWr;
    logic retx;
    logic inc;
    logic rdCnt;
    logic rdMask;
  } cntOp_t;
endpackage

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
  import mbc_pkg::*;
(
  input  logic   loadEn,
  input  logic   incEn,
  input  logic   retxEn,
  input  logic   maskWrEn,
  input  logic   rdCntEn,
  input  logic   rdMaskEn,
  output cntOp_t op
);
  // Priority: load > mask write > retransmit > increment
  always_comb begin
    op        = '0;
    op.load   = loadEn;
    op.maskWr = maskWrEn && !loadEn;
    op.retx   = retxEn && !loadEn && !maskWrEn;
    op.inc    = incEn && !loadEn && !maskWrEn && !retxEn;
    op.rdCnt  = rdCntEn;
    op.rdMask = rdMaskEn && !rdCntEn;
  end
endmodule

// File: rtl/mbc_datapath.sv
module mbc_datapath
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntOp_t            op,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] cntQ,
  output logic [ADDR_W-1:0] maskQ,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic              cntIntN
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] startQ;
  logic [ADDR_W-1:0] maskTrim;
  logic [ADDR_W-1:0] cntStep;
  logic              wrapHit;

  // Keep only the run of ones starting at bit 0
  assign maskTrim[0] = addrIn[0];
  for (genvar i = 1; i < ADDR_W; i++) begin : g_trim
    assign maskTrim[i] = maskTrim[i-1] & addrIn[i];
  end

  assign cntStep = (cntQ & ~maskQ) | ((cntQ + ONE) & maskQ);
  assign wrapHit = (maskQ != '0) && ((cntQ & maskQ) == maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      startQ  <= '0;
      maskQ   <= '1;
      cntIntN <= 1'b1;
    end else begin
      if (op.load) begin
        cntQ    <= addrIn;
        startQ  <= addrIn;
        cntIntN <= 1'b1;
      end else if (op.maskWr) begin
        maskQ <= maskTrim;
      end else if (op.retx) begin
        cntQ <= startQ;
      end else if (op.inc) begin
        cntQ <= cntStep;
        if (wrapHit) cntIntN <= 1'b0;
      end
    end
  end

  always_comb begin
    addrOe  = op.rdCnt | op.rdMask;
    addrOut = '0;
    if (op.rdCnt)       addrOut = cntQ;
    else if (op.rdMask) addrOut = maskQ;
  end
endmodule

// File: rtl/masked_burst_counter.sv
module masked_burst_counter
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic              incEn,
  input  logic              retxEn,
  input  logic              maskWrEn,
  input  logic              rdCntEn,
  input  logic              rdMaskEn,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic              cntIntN
);
  cntOp_t            op;
  logic [ADDR_W-1:0] cntQ;
  logic [ADDR_W-1:0] maskQ;

  mbc_ctrl u_ctrl (
    .loadEn(loadEn), .incEn(incEn), .retxEn(retxEn), .maskWrEn(maskWrEn),
    .rdCntEn(rdCntEn), .rdMaskEn(rdMaskEn), .op(op)
  );

  mbc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .op(op), .addrIn(addrIn),
    .cntQ(cntQ), .maskQ(maskQ), .addrOut(addrOut), .addrOe(addrOe),
    .cntIntN(cntIntN)
  );
endmodule

// File: rtl/mbc_checker.sv
module mbc_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadEn,
  input logic              incEn,
  input logic              retxEn,
  input logic              maskWrEn,
  input logic              rdCntEn,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] addrOut,
  input logic              cntIntN,
  input logic [ADDR_W-1:0] cntQ,
  input logic [ADDR_W-1:0] maskQ
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (cntQ == $past(addrIn)) && cntIntN);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !incEn && !retxEn) |=> $stable(cntQ));

  p_high_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (incEn && !loadEn && !maskWrEn && !retxEn)
      |=> ((cntQ & ~maskQ) == ($past(cntQ) & ~$past(maskQ))));

  p_mask_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    (((maskQ + ONE) & maskQ) == '0));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cntIntN && !loadEn) |=> !cntIntN);

  p_readback_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdCntEn |-> (addrOut == cntQ));
endmodule

bind masked_burst_counter mbc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .incEn(incEn), .retxEn(retxEn),
  .maskWrEn(maskWrEn), .rdCntEn(rdCntEn), .addrIn(addrIn),
  .addrOut(addrOut), .cntIntN(cntIntN), .cntQ(cntQ), .maskQ(maskQ)
);

// File: tb/tb_masked_burst_counter.sv
`timescale 1ns/1ps
module tb_masked_burst_counter;
  logic       clk = 1'b0;
  logic       rstN;
  logic       loadEn, incEn, retxEn, maskWrEn, rdCntEn, rdMaskEn;
  logic [7:0] addrIn;
  logic [7:0] addrOut;
  logic       addrOe, cntIntN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0] mCnt, mMask, mStart;
  logic       mIntN;

  always #2 clk = ~clk;

  masked_burst_counter #(.ADDR_W(8)) dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .incEn(incEn), .retxEn(retxEn),
    .maskWrEn(maskWrEn), .rdCntEn(rdCntEn), .rdMaskEn(rdMaskEn),
    .addrIn(addrIn), .addrOut(addrOut), .addrOe(addrOe), .cntIntN(cntIntN)
  );

  function automatic logic [7:0] lowRun(input logic [7:0] v);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      if (!v[i]) break;
      r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic modelReset();
    mCnt = 8'h00; mStart = 8'h00; mMask = 8'hFF; mIntN = 1'b1;
  endtask

  task automatic modelStep();
    if (loadEn) begin
      mCnt = addrIn; mStart = addrIn; mIntN = 1'b1;
    end else if (maskWrEn) begin
      mMask = lowRun(addrIn);
    end else if (retxEn) begin
      mCnt = mStart;
    end else if (incEn) begin
      if (mMask != 0 && (mCnt & mMask) == mMask) mIntN = 1'b0;
      mCnt = (mCnt & ~mMask) | ((mCnt + 8'd1) & mMask);
    end
  endtask

  task automatic compare(input string tag);
    logic [7:0] expOut;
    logic       expOe;
    expOe  = rdCntEn | rdMaskEn;
    expOut = rdCntEn ? mCnt : (rdMaskEn ? mMask : 8'h00);
    checks++;
    if (addrOut !== expOut || addrOe !== expOe || cntIntN !== mIntN) begin
      errors++;
      $display("FAIL %s: addrOut=%02h oe=%0b int=%0b expected addrOut=%02h oe=%0b int=%0b",
               tag, addrOut, addrOe, cntIntN, expOut, expOe, mIntN);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic ld, input logic inc, input logic rt, input logic mw,
                     input logic rc, input logic rm, input logic [7:0] a, input string tag);
    loadEn = ld; incEn = inc; retxEn = rt; maskWrEn = mw;
    rdCntEn = rc; rdMaskEn = rm; addrIn = a;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic peekMask(input string tag);
    cyc(0, 0, 0, 0, 0, 1, 8'h00, tag);
  endtask

  initial begin
    rstN = 1'b0;
    loadEn = 0; incEn = 0; retxEn = 0; maskWrEn = 0;
    rdCntEn = 1; rdMaskEn = 0; addrIn = 8'h00;
    modelReset();
    repeat (3) @(negedge clk);
    compare("R1 reset counter");
    rdCntEn = 0; rdMaskEn = 1; #0.1;
    compare("R1 reset mask");
    rstN = 1'b1;

    // R2 load and R3 increment under full mask
    cyc(1, 0, 0, 0, 1, 0, 8'h3C, "R2 load");
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 1, 0, 8'h00, "R3 inc full mask");
    cyc(0, 0, 0, 0, 1, 0, 8'h77, "R4 hold");

    // narrow mask, wrap inside window
    cyc(0, 0, 0, 1, 1, 0, 8'h07, "R6 mask write counter unchanged");
    peekMask("R6 mask 07");
    cyc(1, 0, 0, 0, 1, 0, 8'hA5, "R2 load A5");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 1, 0, 8'h00, "R3 inc masked high bits kept");
    cyc(0, 1, 0, 0, 1, 0, 8'h00, "R5 flag stays low after wrap");
    cyc(0, 0, 1, 0, 1, 0, 8'h00, "R7 retransmit to A5, flag held");
    cyc(0, 0, 0, 1, 1, 0, 8'h0B, "R6 non-contiguous write");
    peekMask("R6 mask 0B trimmed to 03");
    cyc(0, 1, 0, 0, 1, 0, 8'h00, "R5 flag held through mask write");
    cyc(1, 0, 0, 0, 1, 0, 8'h12, "R2 load clears flag");

    // zero mask freezes
    cyc(0, 0, 0, 1, 1, 0, 8'hFE, "R6 write FE gives 0");
    peekMask("R6 mask zero");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 1, 0, 8'h00, "R9 zero mask inc frozen");

    // full-width wrap
    cyc(0, 0, 0, 1, 1, 0, 8'hFF, "R6 mask FF");
    cyc(1, 0, 0, 0, 1, 0, 8'hFE, "R2 load FE");
    cyc(0, 1, 0, 0, 1, 0, 8'h00, "R3 inc to FF");
    cyc(0, 1, 0, 0, 1, 0, 8'h00, "R5 full wrap to 00");

    // priority collisions
    cyc(1, 1, 1, 1, 1, 0, 8'h40, "R2 load wins all");
    cyc(0, 1, 1, 1, 1, 0, 8'h0F, "R6 mask write beats retx and inc");
    cyc(0, 1, 0, 0, 1, 0, 8'h00, "R3 inc after collision");
    cyc(0, 1, 1, 0, 1, 0, 8'h00, "R7 retx beats inc");

    // readback selects
    cyc(0, 0, 0, 0, 1, 1, 8'h00, "R8 counter beats mask");
    cyc(0, 0, 0, 0, 0, 1, 8'h00, "R8 mask only");
    cyc(0, 0, 0, 0, 0, 0, 8'h00, "R8 no readback");

    // pseudo-random run
    for (int i = 0; i < 400; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      cyc(r[0] & r[1] & r[2], r[3], r[4] & r[5] & r[6], r[7] & r[1] & r[4],
          1'b1, r[2], 8'($urandom), "R3 R7 random run");
    end

    // asynchronous reset mid-run, no clock edge
    cyc(1, 0, 0, 0, 1, 0, 8'h9D, "R2 load before reset");
    rstN = 1'b0;
    #0.5;
    modelReset();
    compare("R1 async reset counter");
    rdCntEn = 0; rdMaskEn = 1; #0.1;
    compare("R1 async reset mask");
    @(negedge clk);
    rstN = 1'b1;
    cyc(0, 1, 0, 0, 1, 0, 8'h00, "R3 inc after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule